// File: doc/BRIEF.md
# Composite Clock AMI Transmitter

This block produces a 64 kHz composite timing signal as two rail outputs, a positive-pulse rail and a negative-pulse rail, for an external line driver. An upstream timing source supplies a strobe, `tick`, that pulses for one system-clock cycle eight times per bit period. Each bit period is eight ticks long. Every bit carries one mark, and the polarity of consecutive marks alternates.

On top of this alternate-mark-inversion stream the block can insert a bipolar violation on the eighth bit of every frame. A violation is a mark that repeats the previous polarity, and it carries the 8 kHz frame phase. A second control adds a 400 Hz marker by leaving out the violation once every twenty frames. The pulse width is selectable between half and five eighths of the bit period. A one-cycle `frame_strobe` marks each violation that is actually sent, so downstream logic can align to the frame.

Top module: `cc_ami_tx`

## Requirements
- R1: A synchronous active-high reset drives both rails and `frame_strobe` low and clears the tick phase, bit-in-frame and frame counters. The first mark after reset is positive.
- R2: Every bit period of eight ticks carries exactly one mark, which starts at the first tick of the bit. A mark that is not a violation has the opposite polarity to the mark before it.
- R3: When `frame_en` is 1, the mark of the eighth bit of each frame repeats the previous polarity. Bits are counted from reset, and frames are groups of eight bits.
- R4: When `frame_en` is 0, polarity alternates on every bit, no violation occurs and `frame_strobe` stays low.
- R5: When `duty_long` is 0, the active rail is high for ticks 0 to 3 of the bit. When `duty_long` is 1, it is high for ticks 0 to 4. It is low for the rest of the bit.
- R6: When `marker_en` is 1 and `frame_en` is 1, the violation is left out in frame 19 of every cycle of twenty frames (frames numbered 0 to 19 from reset). That bit then alternates normally and raises no strobe.
- R7: `frame_strobe` is high for exactly one clock cycle, in the same cycle that the rail pulse of a violation bit begins.
- R8: `pos_rail` and `neg_rail` are never high together.
- R9: The rails change only in the clock cycle that follows a sampled `tick`. In all other cycles they hold their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle strobe at eight times the bit rate |
| duty_long | input | 1 | 0 selects a 4/8 pulse, 1 selects a 5/8 pulse |
| frame_en | input | 1 | Enables the 8 kHz bipolar violations |
| marker_en | input | 1 | Enables the 400 Hz marker (omitted violation) |
| pos_rail | output | 1 | Positive pulse rail |
| neg_rail | output | 1 | Negative pulse rail |
| frame_strobe | output | 1 | One-cycle pulse at the start of each violation bit |

## Verification
The frame violation and the 400 Hz omission both fall on the same bit: the eighth bit of frame 19. The bench provokes this by running more than twenty frames with both enables set. It checks that the polarity on that bit alternates instead of repeating, and that no strobe appears there. The strobe and the leading edge of a rail pulse also fall in one cycle. Every tick cycle is compared for both against a tick-counting model, while idle cycles are checked for held rails and a low strobe.

// File: rtl/cc_ami_pkg.sv
package cc_ami_pkg;

  typedef struct packed {
    logic pos;
    logic neg;
  } rail_t;

  function automatic rail_t drive_rails(input logic active, input logic positive);
    rail_t r;
    r.pos = active & positive;
    r.neg = active & ~positive;
    return r;
  endfunction

endpackage

// File: rtl/cc_phase_ctr.sv
module cc_phase_ctr #(
  parameter int N = 8,
  localparam int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  output logic [PW-1:0] phase,
  output logic          bit_start,
  output logic          bit_last
);

  localparam logic [PW-1:0] LAST = PW'(N - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
    end else if (tick) begin
      if (phase == LAST) phase <= '0;
      else               phase <= phase + 1'b1;
    end
  end

  assign bit_start = tick && (phase == '0);
  assign bit_last  = tick && (phase == LAST);

endmodule

// File: rtl/cc_frame_seq.sv
module cc_frame_seq #(
  parameter int SLOTS  = 8,
  parameter int FRAMES = 20,
  localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int FW = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  output logic viol_slot,
  output logic mark_frame
);

  localparam logic [SW-1:0] SLOT_LAST  = SW'(SLOTS - 1);
  localparam logic [FW-1:0] FRAME_LAST = FW'(FRAMES - 1);

  logic [SW-1:0] slot_q;
  logic [FW-1:0] frame_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q  <= '0;
      frame_q <= '0;
    end else if (adv) begin
      if (slot_q == SLOT_LAST) begin
        slot_q <= '0;
        if (frame_q == FRAME_LAST) frame_q <= '0;
        else                       frame_q <= frame_q + 1'b1;
      end else begin
        slot_q <= slot_q + 1'b1;
      end
    end
  end

  assign viol_slot  = (slot_q == SLOT_LAST);
  assign mark_frame = (frame_q == FRAME_LAST);

endmodule

// File: rtl/cc_pol_gen.sv
module cc_pol_gen (
  input  logic clk,
  input  logic rst,
  input  logic bit_start,
  input  logic viol,
  output logic pol_now
);

  // pol_q = 1 means the most recent mark was positive.
  logic pol_q;
  logic pol_new;

  assign pol_new = viol ? pol_q : ~pol_q;
  assign pol_now = bit_start ? pol_new : pol_q;

  always_ff @(posedge clk) begin
    if (rst)            pol_q <= 1'b0;
    else if (bit_start) pol_q <= pol_new;
  end

endmodule

// File: rtl/cc_ami_tx.sv
module cc_ami_tx #(
  parameter int TICKS_PER_BIT   = 8,
  parameter int BITS_PER_FRAME  = 8,
  parameter int FRAMES_PER_MARK = 20,
  parameter int HIGH_SHORT      = 4,
  parameter int HIGH_LONG       = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic duty_long,
  input  logic frame_en,
  input  logic marker_en,
  output logic pos_rail,
  output logic neg_rail,
  output logic frame_strobe
);
  import cc_ami_pkg::*;

  localparam int PW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;

  logic [PW-1:0] phase;
  logic          bit_start;
  logic          bit_last;
  logic          viol_slot;
  logic          mark_frame;
  logic          viol;
  logic          pol_now;
  logic          active;
  int            high_ticks;
  rail_t         rails_d;

  cc_phase_ctr #(.N(TICKS_PER_BIT)) u_phase (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .phase     (phase),
    .bit_start (bit_start),
    .bit_last  (bit_last)
  );

  cc_frame_seq #(.SLOTS(BITS_PER_FRAME), .FRAMES(FRAMES_PER_MARK)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .adv        (bit_last),
    .viol_slot  (viol_slot),
    .mark_frame (mark_frame)
  );

  assign viol = frame_en && viol_slot && !(marker_en && mark_frame);

  cc_pol_gen u_pol (
    .clk       (clk),
    .rst       (rst),
    .bit_start (bit_start),
    .viol      (viol),
    .pol_now   (pol_now)
  );

  assign high_ticks = duty_long ? HIGH_LONG : HIGH_SHORT;
  assign active     = (int'(phase) < high_ticks);
  assign rails_d    = drive_rails(active, pol_now);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_rail     <= 1'b0;
      neg_rail     <= 1'b0;
      frame_strobe <= 1'b0;
    end else begin
      frame_strobe <= bit_start && viol;
      if (tick) begin
        pos_rail <= rails_d.pos;
        neg_rail <= rails_d.neg;
      end
    end
  end

endmodule

// File: rtl/cc_ami_tx_chk.sv
module cc_ami_tx_chk (
  input logic clk,
  input logic rst,
  input logic tick,
  input logic frame_en,
  input logic pos_rail,
  input logic neg_rail,
  input logic frame_strobe
);

  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (!pos_rail && !neg_rail && !frame_strobe));

  p_no_overlap_r8: assert property (@(posedge clk) disable iff (rst)
    !(pos_rail && neg_rail));

  p_strobe_single_r7: assert property (@(posedge clk) disable iff (rst)
    frame_strobe |=> !frame_strobe);

  p_strobe_on_mark_r7: assert property (@(posedge clk) disable iff (rst)
    frame_strobe |-> (pos_rail || neg_rail));

  p_hold_between_ticks_r9: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(pos_rail) && $stable(neg_rail)));

  p_no_strobe_off_r4: assert property (@(posedge clk) disable iff (rst)
    !frame_en |=> !frame_strobe);

endmodule

bind cc_ami_tx cc_ami_tx_chk chk_i (
  .clk          (clk),
  .rst          (rst),
  .tick         (tick),
  .frame_en     (frame_en),
  .pos_rail     (pos_rail),
  .neg_rail     (neg_rail),
  .frame_strobe (frame_strobe)
);

// File: tb/cc_ami_tx_tb_top.sv
`timescale 1ns/1ps
module cc_ami_tx_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic duty_long = 1'b0;
  logic frame_en = 1'b0;
  logic marker_en = 1'b0;
  logic pos_rail, neg_rail, frame_strobe;

  int n_checks = 0;
  int n_fails  = 0;

  always #2.5 clk = ~clk;

  cc_ami_tx dut_i (
    .clk          (clk),
    .rst          (rst),
    .tick         (tick),
    .duty_long    (duty_long),
    .frame_en     (frame_en),
    .marker_en    (marker_en),
    .pos_rail     (pos_rail),
    .neg_rail     (neg_rail),
    .frame_strobe (frame_strobe)
  );

  typedef struct {
    logic  p;
    logic  n;
    logic  s;
    string tag;
  } exp_t;

  exp_t exp_q[$];

  // reference model state
  int   m_ticks = 0;
  logic m_last  = 1'b0;   // 1 = last mark positive
  logic prev_p  = 1'b0;
  logic prev_n  = 1'b0;

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: {pos,neg,strobe} actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_tick(input int gap);
    exp_t e;
    int   ph, b, slot, fr;
    logic viol, strb, act_hi;
    @(negedge clk);
    ph   = m_ticks % 8;
    b    = m_ticks / 8;
    slot = b % 8;
    fr   = (b / 8) % 20;
    strb = 1'b0;
    viol = 1'b0;
    if (ph == 0) begin
      viol   = frame_en && (slot == 7) && !(marker_en && fr == 19);
      m_last = viol ? m_last : ~m_last;
      strb   = viol;
    end
    act_hi = ph < (duty_long ? 5 : 4);
    e.p = act_hi & m_last;
    e.n = act_hi & ~m_last;
    e.s = strb;
    if (m_ticks == 0)                                              e.tag = "R1";
    else if (strb)                                                 e.tag = "R7";
    else if (ph == 0 && slot == 7 && frame_en && marker_en && fr == 19) e.tag = "R6";
    else if (ph == 0 && viol)                                      e.tag = "R3";
    else if (!frame_en)                                            e.tag = "R4";
    else if (ph == 3 || ph == 4)                                   e.tag = "R5";
    else                                                           e.tag = "R2";
    exp_q.push_back(e);
    m_ticks++;
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", {pos_rail, neg_rail, frame_strobe}, 3'b000);
    m_ticks = 0;
    m_last  = 1'b0;
    rst = 1'b0;
    @(negedge clk);
  endtask

  // monitor / scoreboard
  initial begin
    logic had, rstd;
    exp_t e;
    forever begin
      @(posedge clk);
      had  = tick;
      rstd = rst;
      @(negedge clk);
      if (rstd) begin
        prev_p = 1'b0;
        prev_n = 1'b0;
      end else begin
        n_checks++;
        if (pos_rail && neg_rail) begin
          n_fails++;
          $display("FAIL R8: pos=%b neg=%b expected not both high", pos_rail, neg_rail);
        end
        if (had) begin
          if (exp_q.size() == 0) begin
            n_checks++; n_fails++;
            $display("FAIL R2: output actual=%b%b expected=no pending tick", pos_rail, neg_rail);
          end else begin
            e = exp_q.pop_front();
            check(e.tag, {pos_rail, neg_rail, frame_strobe}, {e.p, e.n, e.s});
            prev_p = e.p;
            prev_n = e.n;
          end
        end else begin
          check("R9", {pos_rail, neg_rail, frame_strobe}, {prev_p, prev_n, 1'b0});
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    do_reset();
    // R2/R3/R5: frame violations with 4/8 pulses, varied tick spacing
    frame_en = 1'b1; duty_long = 1'b0; marker_en = 1'b0;
    for (int i = 0; i < 192; i++) do_tick(i % 3);
    // R5: 5/8 pulse width
    duty_long = 1'b1;
    for (int i = 0; i < 128; i++) do_tick((i % 2) + 1);
    // R4: violations suppressed
    frame_en = 1'b0;
    for (int i = 0; i < 128; i++) do_tick(1);
    // R6: 400 Hz marker, more than twenty frames
    frame_en = 1'b1; marker_en = 1'b1; duty_long = 1'b0;
    for (int i = 0; i < 1408; i++) do_tick(i % 2);
    // R1: mid-run reset, first mark positive again
    for (int i = 0; i < 13; i++) do_tick(0);
    repeat (3) @(negedge clk);
    do_reset();
    for (int i = 0; i < 80; i++) do_tick(1);
    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_checks++; n_fails++;
      $display("FAIL R2: pending=%0d expected=0", exp_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule